// File: doc/BRIEF.md
# Processor Light-Sleep Entry and Wake Controller

This block sits next to a processor core and decides when the core clock may be switched off for a light sleep, and when it must come back. It watches the core's wait-for-interrupt and wait-for-event strobes and its exception-return strobe. It also reads three control bits: a deep-sleep select, a sleep-after-handler flag and a send-event-on-pending flag. Two further inputs are the per-line interrupt pending and enable vectors and a wakeup event input. Sleep is taken only when the request is legal. The block keeps a record of which mechanism put the core to sleep, and the wake rule that applies depends on that record.

While the core sleeps, the clock enable is low and an I/O hold output is high. Control inputs that change during sleep are ignored, because the relevant settings and the run level are captured at entry. Waking takes no extra cycles. The clock enable is high on the cycle right after the wake condition is sampled, and the core goes back to the run level it left, normal or low-power.

Top module: `core_nap_ctrl`

## Requirements
- R1: After reset, `clk_en_o`=1, `io_hold_o`=0, `mode_o`=2'b00 and `cause_o`=2'b00.
- R2: A `wfi_i` strobe while awake, with `deep_sel_i`=0 and no bit of `irq_pend_i` set, puts the block to sleep at the next edge. After that edge `clk_en_o`=0, `io_hold_o`=1, `mode_o[1]`=1 and `cause_o`=2'b01. While awake, `cause_o` is 2'b00.
- R3: Entry by `wfi_i` or by `exc_ret_i` is refused when any pending bit is set, whether that line is enabled or not. With `deep_sel_i`=1, no strobe leads to sleep.
- R4: A `wake_evt_i` pulse while awake sets an internal event flag. A `wfe_i` strobe that finds the flag set clears it and does not sleep. A `wfe_i` strobe with the flag clear and `deep_sel_i`=0 sleeps with `cause_o`=2'b10.
- R5: An `exc_ret_i` strobe sleeps with `cause_o`=2'b11 only when `deep_sel_i`=0, `exit_sleep_i`=1 and no pending bit is set.
- R6: After entry with cause 2'b01 or 2'b11, only a line that is both pending and enabled wakes the block. A wakeup event or a pending but disabled line does not wake it.
- R7: After entry with cause 2'b10 and `pend_wake_i`=0 at entry, only `wake_evt_i` wakes the block. Interrupt lines do not.
- R8: After entry with cause 2'b10 and `pend_wake_i`=1 at entry, `wake_evt_i` wakes the block. So does any line that becomes newly pending, enabled or not. A line that was already pending at entry counts only after it drops and rises again.
- R9: When a wake condition is sampled at an edge, `clk_en_o`=1, `io_hold_o`=0 and `cause_o`=2'b00 right after that edge.
- R10: `mode_o[0]` is `lp_run_i` registered one cycle while awake. It stays frozen while asleep, so a wake returns to the level that was in force at entry. Mode codes: 00 run, 01 low-power run, 10 sleep, 11 low-power sleep.
- R11: Changes to `pend_wake_i`, `deep_sel_i` or `lp_run_i` while asleep have no effect until the next entry.
- R12: When several strobes come together, only the highest-priority one is evaluated. `wfi_i` ranks above `wfe_i`, and `wfe_i` ranks above `exc_ret_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| exc_ret_i | input | 1 | Exception-return strobe |
| deep_sel_i | input | 1 | Deep-sleep select; 1 blocks light sleep |
| exit_sleep_i | input | 1 | Sleep after handler return |
| pend_wake_i | input | 1 | Newly pending lines act as events |
| lp_run_i | input | 1 | Core is in low-power run |
| irq_pend_i | input | N_IRQ | Per-line pending |
| irq_en_i | input | N_IRQ | Per-line enable |
| wake_evt_i | input | 1 | Wakeup event |
| clk_en_o | output | 1 | Core clock enable |
| io_hold_o | output | 1 | Hold I/O state |
| mode_o | output | 2 | {asleep, low-power level} |
| cause_o | output | 2 | Entry cause: 00 none, 01 WFI, 10 WFE, 11 handler exit |

## Verification
The bench sweeps every combination of strobe kind, deep select, after-handler flag, pending state and latched event. A decoder that ignored pending disabled lines, or did not consume the event flag, would sleep or stay awake at the wrong times. For each entry cause it then tries an event, an enabled line and a disabled line under both send-event settings, which catches an exit rule applied to the wrong cause. Three targeted cases cover the remaining traps. A line already pending at entry must not wake the core until it is raised again. A send-event bit flipped during sleep must not change the rule. A low-power run level must be held across sleep and restored after wake.

// File: rtl/nap_pkg.sv
package nap_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_WFI  = 2'b01,
    CAUSE_WFE  = 2'b10,
    CAUSE_EXIT = 2'b11
  } cause_e;

  // Strobe priority: wait-for-interrupt, then wait-for-event, then handler exit.
  function automatic cause_e pick_cause(input logic wfi, input logic wfe, input logic exc);
    if (wfi)      return CAUSE_WFI;
    else if (wfe) return CAUSE_WFE;
    else if (exc) return CAUSE_EXIT;
    else          return CAUSE_NONE;
  endfunction

  // Whether a selected request may actually sleep.
  function automatic logic entry_allowed(input cause_e c, input logic deep,
                                         input logic on_exit, input logic irq_any,
                                         input logic evt_pend);
    logic ok;
    case (c)
      CAUSE_WFI:  ok = !deep && !irq_any;
      CAUSE_WFE:  ok = !deep && !evt_pend;
      CAUSE_EXIT: ok = !deep && on_exit && !irq_any;
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Exit rule chosen by the recorded cause.
  function automatic logic wake_rule(input cause_e c, input logic sev,
                                     input logic en_hit, input logic fresh_any,
                                     input logic evt);
    logic w;
    case (c)
      CAUSE_WFI, CAUSE_EXIT: w = en_hit;
      CAUSE_WFE:             w = evt || (sev && fresh_any);
      default:               w = 1'b0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/nap_entry_dec.sv
module nap_entry_dec
  import nap_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             awake,
  input  logic             wfi,
  input  logic             wfe,
  input  logic             exc,
  input  logic             deep,
  input  logic             on_exit,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic             evt_pend,
  output logic             enter,
  output cause_e           enter_cause,
  output logic             evt_consume
);

  function automatic logic any_line(input logic [N_IRQ-1:0] v);
    return |v;
  endfunction

  cause_e sel;
  logic   irq_any;

  always_comb begin
    irq_any     = any_line(irq_pend);
    sel         = awake ? pick_cause(wfi, wfe, exc) : CAUSE_NONE;
    enter       = entry_allowed(sel, deep, on_exit, irq_any, evt_pend);
    enter_cause = enter ? sel : CAUSE_NONE;
    evt_consume = (sel == CAUSE_WFE) && evt_pend;
  end

endmodule

// File: rtl/nap_evt_latch.sv
module nap_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic awake,
  input  logic wake_evt,
  input  logic consume,
  output logic evt_pend
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (awake)
      flag_q <= (flag_q && !consume) || wake_evt;
  end

  assign evt_pend = flag_q;

endmodule

// File: rtl/nap_wake_dec.sv
module nap_wake_dec
  import nap_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             asleep,
  input  logic             enter,
  input  cause_e           cause,
  input  logic             sev_lat,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wake_evt,
  output logic             en_hit,
  output logic             fresh_any,
  output logic             wake
);

  logic [N_IRQ-1:0] snap_q;
  logic [N_IRQ-1:0] fresh;

  // Per line: remember lines pending at entry; forget a line once it drops.
  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        snap_q[i] <= 1'b0;
      else if (enter)
        snap_q[i] <= irq_pend[i];
      else if (asleep)
        snap_q[i] <= snap_q[i] && irq_pend[i];
      else
        snap_q[i] <= 1'b0;
    end
    assign fresh[i] = irq_pend[i] && !snap_q[i];
  end

  always_comb begin
    en_hit    = |(irq_pend & irq_en);
    fresh_any = |fresh;
    wake      = asleep && wake_rule(cause, sev_lat, en_hit, fresh_any, wake_evt);
  end

endmodule

// File: rtl/nap_mode_seq.sv
module nap_mode_seq
  import nap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enter,
  input  cause_e enter_cause,
  input  logic   wake,
  input  logic   lp_run,
  input  logic   sev_in,
  output logic   asleep,
  output cause_e cause,
  output logic   sev_lat,
  output logic   run_lp
);

  logic   asleep_q;
  cause_e cause_q;
  logic   sev_q;
  logic   lp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
      sev_q    <= 1'b0;
      lp_q     <= 1'b0;
    end else if (asleep_q) begin
      if (wake) begin
        asleep_q <= 1'b0;
        cause_q  <= CAUSE_NONE;
      end
    end else begin
      lp_q <= lp_run;
      if (enter) begin
        asleep_q <= 1'b1;
        cause_q  <= enter_cause;
        sev_q    <= sev_in;
      end
    end
  end

  assign asleep  = asleep_q;
  assign cause   = cause_q;
  assign sev_lat = sev_q;
  assign run_lp  = lp_q;

endmodule

// File: rtl/core_nap_ctrl.sv
module core_nap_ctrl
  import nap_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wfi_i,
  input  logic             wfe_i,
  input  logic             exc_ret_i,
  input  logic             deep_sel_i,
  input  logic             exit_sleep_i,
  input  logic             pend_wake_i,
  input  logic             lp_run_i,
  input  logic [N_IRQ-1:0] irq_pend_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             wake_evt_i,
  output logic             clk_en_o,
  output logic             io_hold_o,
  output logic [1:0]       mode_o,
  output logic [1:0]       cause_o
);

  // Named internal events, also used by the bound checker.
  logic   asleep_w;
  logic   enter_w;
  logic   wake_w;
  logic   evt_pend_w;
  logic   evt_consume_w;
  logic   sev_lat_w;
  logic   run_lp_w;
  logic   en_hit_w;
  logic   fresh_any_w;
  cause_e enter_cause_w;
  cause_e cause_w;

  nap_entry_dec #(.N_IRQ(N_IRQ)) entry_i (
    .awake      (!asleep_w),
    .wfi        (wfi_i),
    .wfe        (wfe_i),
    .exc        (exc_ret_i),
    .deep       (deep_sel_i),
    .on_exit    (exit_sleep_i),
    .irq_pend   (irq_pend_i),
    .evt_pend   (evt_pend_w),
    .enter      (enter_w),
    .enter_cause(enter_cause_w),
    .evt_consume(evt_consume_w)
  );

  nap_evt_latch evt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .awake   (!asleep_w),
    .wake_evt(wake_evt_i),
    .consume (evt_consume_w),
    .evt_pend(evt_pend_w)
  );

  nap_wake_dec #(.N_IRQ(N_IRQ)) wake_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .asleep   (asleep_w),
    .enter    (enter_w),
    .cause    (cause_w),
    .sev_lat  (sev_lat_w),
    .irq_pend (irq_pend_i),
    .irq_en   (irq_en_i),
    .wake_evt (wake_evt_i),
    .en_hit   (en_hit_w),
    .fresh_any(fresh_any_w),
    .wake     (wake_w)
  );

  nap_mode_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter      (enter_w),
    .enter_cause(enter_cause_w),
    .wake       (wake_w),
    .lp_run     (lp_run_i),
    .sev_in     (pend_wake_i),
    .asleep     (asleep_w),
    .cause      (cause_w),
    .sev_lat    (sev_lat_w),
    .run_lp     (run_lp_w)
  );

  assign clk_en_o  = !asleep_w;
  assign io_hold_o = asleep_w;
  assign mode_o    = {asleep_w, run_lp_w};
  assign cause_o   = cause_w;

endmodule

// File: rtl/nap_ctrl_chk.sv
module nap_ctrl_chk #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wfi_i,
  input logic             wfe_i,
  input logic             exc_ret_i,
  input logic             deep_sel_i,
  input logic             exit_sleep_i,
  input logic [N_IRQ-1:0] irq_pend_i,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic             wake_evt_i,
  input logic             clk_en_o,
  input logic [1:0]       mode_o,
  input logic [1:0]       cause_o,
  input logic             wake_w,
  input logic             evt_pend_w
);

  logic awake;
  assign awake = !mode_o[1];

  // R2: legal wait-for-interrupt sleeps with the right cause
  p_wfi_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    awake && wfi_i && !deep_sel_i && !(|irq_pend_i) |=> mode_o[1] && cause_o == 2'b01);

  // R2: no cause recorded while awake
  p_cause_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    awake |-> cause_o == 2'b00);

  // R3: pending line blocks wait-for-interrupt
  p_pend_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    awake && wfi_i && (|irq_pend_i) |=> !mode_o[1]);

  // R3: deep select blocks every entry
  p_deep_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    awake && deep_sel_i && (wfi_i || wfe_i || exc_ret_i) |=> !mode_o[1]);

  // R4: latched event is consumed instead of sleeping
  p_wfe_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    awake && wfe_i && !wfi_i && evt_pend_w && !wake_evt_i |=> !mode_o[1] && !evt_pend_w);

  // R5: handler-exit entry needs the after-handler flag
  p_exit_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    awake && exc_ret_i && !wfi_i && !wfe_i && !deep_sel_i && exit_sleep_i && !(|irq_pend_i)
    |=> mode_o[1] && cause_o == 2'b11);

  // R6: interrupt-type sleep ignores everything but enabled lines
  p_irq_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[1] && cause_o[0] && !(|(irq_pend_i & irq_en_i)) |=> mode_o[1]);

  // R9: no extra wake latency
  p_wake_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_w |=> clk_en_o && cause_o == 2'b00);

  // R10: run level frozen while asleep
  p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[1] |=> $stable(mode_o[0]));

endmodule

bind core_nap_ctrl nap_ctrl_chk #(.N_IRQ(N_IRQ)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wfi_i       (wfi_i),
  .wfe_i       (wfe_i),
  .exc_ret_i   (exc_ret_i),
  .deep_sel_i  (deep_sel_i),
  .exit_sleep_i(exit_sleep_i),
  .irq_pend_i  (irq_pend_i),
  .irq_en_i    (irq_en_i),
  .wake_evt_i  (wake_evt_i),
  .clk_en_o    (clk_en_o),
  .mode_o      (mode_o),
  .cause_o     (cause_o),
  .wake_w      (wake_w),
  .evt_pend_w  (evt_pend_w)
);

// File: tb/core_nap_ctrl_tb_top.sv
module core_nap_ctrl_tb_top;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi = 1'b0, wfe = 1'b0, exc = 1'b0;
  logic deep = 1'b0, onexit = 1'b0, sev = 1'b0, lp = 1'b0;
  logic [N-1:0] pend = '0, en = '0;
  logic evt = 1'b0;
  logic clk_en, io_hold;
  logic [1:0] mode, cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  core_nap_ctrl #(.N_IRQ(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .exc_ret_i(exc),
    .deep_sel_i(deep), .exit_sleep_i(onexit), .pend_wake_i(sev), .lp_run_i(lp),
    .irq_pend_i(pend), .irq_en_i(en), .wake_evt_i(evt),
    .clk_en_o(clk_en), .io_hold_o(io_hold), .mode_o(mode), .cause_o(cause)
  );

  // Advance one edge; inputs change and outputs are sampled 2 ns later.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {wfi, wfe, exc, deep, onexit, sev, lp, evt} = '0;
    pend = '0; en = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  // kind: 1 wfi, 2 wfe, 3 handler exit
  task automatic strobe(input int kind);
    wfi = (kind == 1); wfe = (kind == 2); exc = (kind == 3);
    tick();
    {wfi, wfe, exc} = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 clk_en", clk_en, 1);
    chk("R1 io_hold", io_hold, 0);
    chk("R1 mode", mode, 0);
    chk("R1 cause", cause, 0);

    // Entry sweep: R2 R3 R4 R5
    for (int k = 1; k <= 3; k++)
      for (int d = 0; d < 2; d++)
        for (int o = 0; o < 2; o++)
          for (int p = 0; p < 2; p++)
            for (int e = 0; e < 2; e++) begin
              bit exp_sl;
              do_reset();
              deep = d[0]; onexit = o[0];
              if (e == 1) begin evt = 1'b1; tick(); evt = 1'b0; end
              pend = (p == 1) ? 8'h04 : 8'h00;  // disabled line
              strobe(k);
              case (k)
                1: exp_sl = !d[0] && !p[0];
                2: exp_sl = !d[0] && !e[0];
                default: exp_sl = !d[0] && o[0] && !p[0];
              endcase
              chk($sformatf("R2/R3/R5 sleep k=%0d d=%0d o=%0d p=%0d e=%0d", k, d, o, p, e),
                  mode[1], exp_sl);
              chk("R2 clk_en", clk_en, !exp_sl);
              chk("R2 io_hold", io_hold, exp_sl);
              chk("R2 cause", cause, exp_sl ? k : 0);
              if (k == 2 && e == 1 && d == 0) begin
                // R4: event consumed, so a second wfe now sleeps
                strobe(2);
                chk("R4 consumed then sleep", mode[1], 1);
              end
            end

    // Wake sweep: R6 R7 R8 R9
    for (int k = 1; k <= 3; k++)
      for (int s = 0; s < 2; s++)
        for (int st = 0; st < 3; st++) begin
          bit exp_w;
          do_reset();
          onexit = 1'b1; sev = s[0];
          strobe(k);
          chk("R2 asleep before stim", mode[1], 1);
          case (st)
            0: evt = 1'b1;
            1: begin pend = 8'h02; en = 8'h02; end
            default: begin pend = 8'h08; en = 8'h00; end
          endcase
          tick();
          evt = 1'b0;
          if (k == 2) exp_w = (st == 0) || (s == 1);
          else        exp_w = (st == 1);
          chk($sformatf("R6/R7/R8/R9 wake k=%0d sev=%0d stim=%0d", k, s, st), clk_en, exp_w);
          chk("R9 cause after", cause, exp_w ? 0 : k);
          chk("R9 io_hold", io_hold, !exp_w);
        end

    // R8: line pending at entry must drop and rise again
    do_reset();
    sev = 1'b1; pend = 8'h01;
    strobe(2);
    chk("R8 entered with pending", mode[1], 1);
    tick();
    chk("R8 old line no wake", clk_en, 0);
    pend = 8'h00; tick();
    chk("R8 drop no wake", clk_en, 0);
    pend = 8'h01; tick();
    chk("R8 re-raise wakes", clk_en, 1);

    // R11: send-event bit changed while asleep is ignored
    do_reset();
    strobe(2);
    sev = 1'b1; deep = 1'b1;
    pend = 8'h10; tick();
    chk("R11 sev change ignored", clk_en, 0);
    evt = 1'b1; tick(); evt = 1'b0;
    chk("R11 event still wakes", clk_en, 1);

    // R10: low-power level held across sleep
    do_reset();
    lp = 1'b1; tick();
    chk("R10 lp run", mode, 1);
    strobe(1);
    chk("R10 lp sleep", mode, 3);
    lp = 1'b0; tick();
    chk("R10 frozen", mode, 3);
    pend = 8'h01; en = 8'h01; tick();
    chk("R10 back to lp run", mode, 1);
    pend = 8'h00; tick();
    chk("R10 follows live", mode, 0);

    // R12: priority
    do_reset();
    pend = 8'h01;
    wfi = 1'b1; wfe = 1'b1; tick(); {wfi, wfe} = '0;
    chk("R12 wfi over wfe refused", mode[1], 0);
    pend = 8'h00;
    wfe = 1'b1; exc = 1'b1; tick(); {wfe, exc} = '0;
    chk("R12 wfe over exit", cause, 2);

    finish_run();
  end

endmodule